// File: doc/BRIEF.md
# Signed-Fraction Sprite Position Accumulator

This block holds one sprite coordinate as an unsigned integer part and a two's-complement fraction. The fraction counts in 1/256 pixel and runs from -128 to +127. The integer part is therefore always the pixel nearest the true position. A stored signed velocity is added to the fraction once for each frame strobe.

The integer part moves only when that addition overflows in the signed sense. The fraction keeps its wrapped sum with no correction afterwards. A load writes position and velocity together. An on-grid output reports a fraction of exactly zero, and a one-cycle step pulse with a direction bit marks each integer move.

Top module: `sprite_frac_pos`

## Requirements
- R1: While `rst` is high on a clock edge, integer, fraction and velocity are cleared. After reset `pos_int`=0, `pos_frac`=0, `on_grid`=1, `step_pulse`=0 and `step_dir`=0.
- R2: A cycle with `load` high writes `pos_int_in`, `pos_frac_in` and `vel_in` into the block. Cycles with neither `load` nor `frame_tick` leave every output unchanged.
- R3: A `frame_tick` without `load` replaces the fraction with the low 8 bits of fraction + velocity, with carry-in 0. The sum is stored as it is, even when the integer moves.
- R4: If that addition overflows in the signed sense and the new fraction has bit 7 set, the integer increments. In the same cycle `step_pulse`=1 and `step_dir`=1.
- R5: If that addition overflows in the signed sense and the new fraction has bit 7 clear, the integer decrements. In the same cycle `step_pulse`=1 and `step_dir`=0.
- R6: Signed overflow means that both operands share a sign and the sum has the other sign. A fraction that wraps between 0xFF and 0x00 without signed overflow leaves the integer unchanged.
- R7: The integer part wraps modulo 256, so 0xFF+1 gives 0x00 and 0x00-1 gives 0xFF.
- R8: `on_grid` is 1 exactly when `pos_frac` is 0x00.
- R9: When `load` and `frame_tick` are high in the same cycle, the load is applied and no update takes place (`step_pulse`=0).
- R10: `step_pulse` is high for exactly the cycle after a stepping tick. It is low after every load, every idle cycle and every tick without overflow.
- R11: For any velocity, the outputs match integer = round(P/256) and fraction = P mod 256 after every tick, where P is a 16-bit count of 1/256 pixel advanced by the sign-extended velocity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Write position and velocity |
| pos_int_in | input | 8 | Integer part to load |
| pos_frac_in | input | 8 | Signed fraction to load |
| vel_in | input | 8 | Signed velocity to load |
| frame_tick | input | 1 | Apply one velocity update |
| pos_int | output | 8 | Integer part (nearest pixel) |
| pos_frac | output | 8 | Signed fraction, 1/256 pixel |
| on_grid | output | 1 | Fraction is exactly zero |
| step_pulse | output | 1 | Integer moved on the last update |
| step_dir | output | 1 | Direction of last step, 1 = up |

## Verification
The bench targets these corner cases:

- A fraction wrapping through 0xFF/0x00. A design that keys on the unsigned carry would step the integer falsely here.
- A velocity of -128 from fractions 0x00 and 0x80. A design that tests operand signs wrongly gets the step wrong or misses it.
- The integer wrapping at 0x00 and 0xFF.
- A load that collides with a tick. A design that lets the update through would move the position it has just loaded.
- A design that re-centres the fraction after a step drifts away from the rounded reference position. Long random runs against that reference expose the drift.

// File: rtl/sprite_frac_pos.sv
module sprite_frac_pos #(
  parameter int W_INT  = 8,
  parameter int W_FRAC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [W_INT-1:0]  pos_int_in,
  input  logic [W_FRAC-1:0] pos_frac_in,
  input  logic [W_FRAC-1:0] vel_in,
  input  logic              frame_tick,
  output logic [W_INT-1:0]  pos_int,
  output logic [W_FRAC-1:0] pos_frac,
  output logic              on_grid,
  output logic              step_pulse,
  output logic              step_dir
);
  localparam int MSB = W_FRAC - 1;

  logic [W_FRAC-1:0] vel_q;
  logic [W_FRAC-1:0] sum;
  logic              ovf;
  logic              upd;

  assign upd     = frame_tick && !load;
  assign sum     = pos_frac + vel_q;
  assign ovf     = (pos_frac[MSB] == vel_q[MSB]) && (sum[MSB] != pos_frac[MSB]);
  assign on_grid = (pos_frac == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_int    <= '0;
      pos_frac   <= '0;
      vel_q      <= '0;
      step_pulse <= 1'b0;
      step_dir   <= 1'b0;
    end else if (load) begin
      pos_int    <= pos_int_in;
      pos_frac   <= pos_frac_in;
      vel_q      <= vel_in;
      step_pulse <= 1'b0;
    end else if (upd) begin
      pos_frac   <= sum;
      step_pulse <= ovf;
      if (ovf) begin
        step_dir <= sum[MSB];
        pos_int  <= sum[MSB] ? pos_int + 1'b1 : pos_int - 1'b1;
      end
    end else begin
      step_pulse <= 1'b0;
    end
  end

  a_r3_frac_sum: assert property (@(posedge clk) disable iff (rst)
    upd |=> pos_frac == W_FRAC'($past(pos_frac) + $past(vel_q)));

  a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && step_dir) |-> pos_int == W_INT'($past(pos_int) + 1'b1));

  a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && !step_dir) |-> pos_int == W_INT'($past(pos_int) - 1'b1));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (upd && pos_frac[MSB] != vel_q[MSB]) |=> ($stable(pos_int) && !step_pulse));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> (pos_int == $past(pos_int_in) && pos_frac == $past(pos_frac_in) && !step_pulse));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!load && !frame_tick) |=> ($stable(pos_int) && $stable(pos_frac) && !step_pulse));
endmodule

// File: tb/sim_sprite_frac_pos.sv
module sim_sprite_frac_pos;
  logic       clk = 1'b0;
  logic       rst, load, frame_tick;
  logic [7:0] pos_int_in, pos_frac_in, vel_in;
  logic [7:0] pos_int, pos_frac;
  logic       on_grid, step_pulse, step_dir;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sprite_frac_pos u0 (
    .clk(clk), .rst(rst), .load(load), .pos_int_in(pos_int_in),
    .pos_frac_in(pos_frac_in), .vel_in(vel_in), .frame_tick(frame_tick),
    .pos_int(pos_int), .pos_frac(pos_frac), .on_grid(on_grid),
    .step_pulse(step_pulse), .step_dir(step_dir)
  );

  // {int0, frac0, vel, exp_int, exp_frac, exp_pulse, exp_dir}
  localparam int NV = 10;
  localparam logic [41:0] VEC [NV] = '{
    {8'h10, 8'h00, 8'h20, 8'h10, 8'h20, 2'b00},  // R3 plain add
    {8'h10, 8'h70, 8'h20, 8'h11, 8'h90, 2'b11},  // R4 up, frac not re-centred
    {8'h10, 8'h90, 8'hE0, 8'h0F, 8'h70, 2'b10},  // R5 down
    {8'h10, 8'hFF, 8'h01, 8'h10, 8'h00, 2'b00},  // R6 -1 -> 0
    {8'h10, 8'h00, 8'hFF, 8'h10, 8'hFF, 2'b00},  // R6 0 -> -1
    {8'hFF, 8'h7F, 8'h01, 8'h00, 8'h80, 2'b11},  // R7 wrap up
    {8'h00, 8'h80, 8'hFF, 8'hFF, 8'h7F, 2'b10},  // R7 wrap down
    {8'h05, 8'h80, 8'h80, 8'h04, 8'h00, 2'b10},  // R5 -128 + -128
    {8'h05, 8'h7F, 8'h7F, 8'h06, 8'hFE, 2'b11},  // R4 +127 + +127
    {8'h05, 8'h00, 8'h80, 8'h05, 8'h80, 2'b00}   // R6 0 + -128
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] i, input logic [7:0] f, input logic [7:0] v);
    @(negedge clk);
    load = 1; pos_int_in = i; pos_frac_in = f; vel_in = v;
    @(negedge clk);
    load = 0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    frame_tick = 1;
    @(negedge clk);
    frame_tick = 0;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1; load = 0; frame_tick = 0;
    pos_int_in = 8'h5A; pos_frac_in = 8'h33; vel_in = 8'h11;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 int", pos_int, 0);
    chk("R1 frac", pos_frac, 0);
    chk("R1 grid/pulse/dir", {on_grid, step_pulse, step_dir}, 3'b100);
    // R1 velocity cleared: tick leaves position at zero
    do_tick();
    chk("R1 vel zero", {pos_int, pos_frac, step_pulse}, {8'h00, 8'h00, 1'b0});

    // table walk
    for (int k = 0; k < NV; k++) begin
      logic [41:0] e;
      e = VEC[k];
      do_load(e[41:34], e[33:26], e[25:18]);
      chk("R2 load int", pos_int, e[41:34]);
      chk("R2 load frac", pos_frac, e[33:26]);
      do_tick();
      chk("R3 frac", pos_frac, e[9:2]);
      chk("R4/R5/R7 int", pos_int, e[17:10]);
      chk("R4/R5 pulse", step_pulse, e[1]);
      if (e[1]) chk("R4/R5 dir", step_dir, e[0]);
      chk("R8 on_grid", on_grid, (e[9:2] == 8'h00));
      @(negedge clk);
      chk("R10 pulse drops", step_pulse, 0);
    end

    // R2 idle hold
    do_load(8'h40, 8'h12, 8'h7F);
    repeat (5) @(negedge clk);
    chk("R2 idle hold", {pos_int, pos_frac, step_pulse}, {8'h40, 8'h12, 1'b0});

    // R9 load wins over tick
    do_load(8'h20, 8'h7F, 8'h7F);
    @(negedge clk);
    load = 1; frame_tick = 1; pos_int_in = 8'h33; pos_frac_in = 8'h7E; vel_in = 8'h02;
    @(negedge clk);
    load = 0; frame_tick = 0;
    chk("R9 load priority", {pos_int, pos_frac, step_pulse}, {8'h33, 8'h7E, 1'b0});
    do_tick();
    chk("R9 new vel used", {pos_int, pos_frac, step_pulse, step_dir}, {8'h34, 8'h80, 1'b1, 1'b1});

    // R11 random tracking against rounded 16-bit reference
    for (int r = 0; r < 30; r++) begin
      logic [7:0]  i0, f0, v0;
      logic [15:0] p, q;
      i0 = 8'($urandom); f0 = 8'($urandom); v0 = 8'($urandom);
      p = {i0, 8'h00} + {{8{f0[7]}}, f0};
      do_load(i0, f0, v0);
      for (int t = 0; t < 40; t++) begin
        do_tick();
        p = p + {{8{v0[7]}}, v0};
        q = p + 16'd128;
        chk("R11 int", pos_int, q[15:8]);
        chk("R11 frac", pos_frac, p[7:0]);
        chk("R8 grid", on_grid, (p[7:0] == 8'h00));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule